// File: doc/BRIEF.md
# Peripheral Powerdown Register Gate

This block sits between a simple memory-mapped register bus and the register file of a peripheral. It holds a single sleep bit in a control register. While the sleep bit is set, the block drives a power-down enable toward the peripheral's memories and register arrays. It also fences off every register except the control register. The bus takes one request per cycle and returns exactly one response per request, one clock later. The response carries read data and an error flag. Nothing ever stalls.

Software powers a peripheral down by setting the sleep bit and then slowing its clocks. The block itself never gates a clock, so all of its logic keeps running while asleep. To wake the peripheral, software restores the clocks, clears the sleep bit, rewrites any configuration it needs, and finally sets the enable bit again.

While asleep, reads of fenced registers return zero on time. Writes to fenced registers are refused with an error and change nothing. The peripheral's own logic is represented by a small bank of generic 32-bit read/write registers next to a one-bit enable register.

Top module: `periph_sleep_gate`

## Requirements
- R1: After synchronous reset, mem_pd_en, periph_en and rsp_valid are 0, and the enable register and every bank register read as zero.
- R2: Every request cycle (req_valid=1) produces rsp_valid=1 in exactly the following cycle, and a cycle without a request produces rsp_valid=0 in the next cycle.
- R3: The control register is at byte offset 0xFF4. Its bit 31 is the sleep bit. After a control write, mem_pd_en equals the written bit 31. Reads return the sleep bit in bit 31 and zero elsewhere. Writes to the other bits have no effect. Control accesses never return an error, whether asleep or awake.
- R4: While asleep, a read of any address other than the control register returns rsp_rdata=0 with rsp_err=0 in the normal response cycle.
- R5: While asleep, a write to any address other than the control register returns rsp_err=1 and leaves the addressed register unchanged.
- R6: While awake, the enable register at byte offset 0x000 (bit 0, other bits read 0) drives periph_en. Bank register i at byte offset 0x004+4*i is a full 32-bit read/write register. Both are written without error.
- R7: A control write with bit 31 set clears the enable bit. periph_en stays 0 while asleep, and the enable register cannot be set until the sleep bit is cleared.
- R8: Clearing the sleep bit restores normal access, and bank register contents written before powerdown are still there afterwards.
- R9: While awake, an address that maps to no register reads as 0 without error, and a write to it returns rsp_err=1 and changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, never gated by this block |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | ADDR_W (12) | Byte offset; bits 1:0 ignored |
| req_wdata | input | DATA_W (32) | Write data |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | DATA_W (32) | Read data, zero for writes |
| rsp_err | output | 1 | Error response for a refused write |
| mem_pd_en | output | 1 | Power-down enable to peripheral memories and register arrays |
| periph_en | output | 1 | Peripheral enable, low while asleep |

## Verification
Reads and writes go to every register class (control, enable, bank, unmapped) in both the awake and the asleep state. This separates address decoding from sleep fencing. A control write with every bit except 31 set shows whether only the sleep bit is decoded. Distinct data patterns are written to each bank register before sleep and read back after wake. This shows whether fenced writes leak into storage and whether the bank index decodes correctly. Enable writes during sleep, plus readback after wake, show whether the enable bit is cleared on entry and held low.

// File: rtl/psg_pkg.sv
package psg_pkg;

  typedef enum logic [1:0] {
    RG_NONE   = 2'd0,
    RG_CTRL   = 2'd1,
    RG_ENABLE = 2'd2,
    RG_BANK   = 2'd3
  } region_e;

  // Map a word index onto a register class.
  function automatic region_e classify(input int unsigned word,
                                       input int unsigned ctrl_word,
                                       input int unsigned en_word,
                                       input int unsigned bank_base,
                                       input int unsigned bank_n);
    if (word == ctrl_word)                                 return RG_CTRL;
    else if (word == en_word)                              return RG_ENABLE;
    else if (word >= bank_base && word < bank_base + bank_n) return RG_BANK;
    else                                                   return RG_NONE;
  endfunction

  // Control register image: only the sleep bit is visible.
  function automatic logic [31:0] ctrl_image(input logic sleep_bit, input int unsigned pos);
    logic [31:0] v;
    v = '0;
    v[pos] = sleep_bit;
    return v;
  endfunction

endpackage

// File: rtl/psg_decode.sv
module psg_decode
  import psg_pkg::*;
#(
  parameter int ADDR_W    = 12,
  parameter int NUM_REGS  = 4,
  parameter int CTRL_OFS  = 'hFF4,
  parameter int EN_OFS    = 'h000,
  parameter int BANK_OFS  = 'h004,
  localparam int IDX_W    = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic [ADDR_W-1:0] addr,
  output region_e           region,
  output logic [IDX_W-1:0]  bank_idx
);
  localparam int unsigned CTRL_WORD = CTRL_OFS / 4;
  localparam int unsigned EN_WORD   = EN_OFS / 4;
  localparam int unsigned BANK_WORD = BANK_OFS / 4;

  int unsigned word;

  always_comb begin
    word     = int'(addr[ADDR_W-1:2]);
    region   = classify(word, CTRL_WORD, EN_WORD, BANK_WORD, NUM_REGS);
    bank_idx = IDX_W'(word - BANK_WORD);
  end
endmodule

// File: rtl/psg_ctrl.sv
module psg_ctrl (
  input  logic clk,
  input  logic rst,
  input  logic ctrl_wr,
  input  logic ctrl_bit,
  input  logic en_wr,
  input  logic en_bit,
  output logic sleep_q,
  output logic enable_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      sleep_q <= 1'b0;
    end else if (ctrl_wr) begin
      sleep_q <= ctrl_bit;
    end
  end

  // Entering sleep drops the enable; it must be set again after wake.
  always_ff @(posedge clk) begin
    if (rst) begin
      enable_q <= 1'b0;
    end else if (ctrl_wr && ctrl_bit) begin
      enable_q <= 1'b0;
    end else if (en_wr) begin
      enable_q <= en_bit;
    end
  end
endmodule

// File: rtl/psg_bank.sv
module psg_bank #(
  parameter int NUM_REGS = 4,
  parameter int DATA_W   = 32,
  localparam int IDX_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata
);
  logic [DATA_W-1:0] regs [NUM_REGS];

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[g] <= '0;
      end else if (wr_en && (int'(idx) == g)) begin
        regs[g] <= wdata;
      end
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (int'(idx) == i) rdata = regs[i];
    end
  end
endmodule

// File: rtl/periph_sleep_gate.sv
module periph_sleep_gate
  import psg_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int NUM_REGS = 4,
  parameter int CTRL_OFS = 'hFF4,
  parameter int EN_OFS   = 'h000,
  parameter int BANK_OFS = 'h004,
  parameter int PD_BIT   = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              rsp_err,
  output logic              mem_pd_en,
  output logic              periph_en
);
  localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  region_e           region;
  logic [IDX_W-1:0]  bank_idx;
  logic [DATA_W-1:0] bank_rdata;
  logic [DATA_W-1:0] rd_value;
  logic              sleep_q, enable_q;

  // Named events for the checker.
  logic ctrl_hit, rd_req, wr_req, wr_blocked, rd_masked;
  logic ctrl_wr, en_wr, bank_wr;

  psg_decode #(
    .ADDR_W(ADDR_W), .NUM_REGS(NUM_REGS),
    .CTRL_OFS(CTRL_OFS), .EN_OFS(EN_OFS), .BANK_OFS(BANK_OFS)
  ) u_decode (
    .addr(req_addr), .region(region), .bank_idx(bank_idx)
  );

  always_comb begin
    ctrl_hit   = (region == RG_CTRL);
    rd_req     = req_valid && !req_write;
    wr_req     = req_valid && req_write;
    ctrl_wr    = wr_req && ctrl_hit;
    en_wr      = wr_req && !sleep_q && (region == RG_ENABLE);
    bank_wr    = wr_req && !sleep_q && (region == RG_BANK);
    wr_blocked = wr_req && !ctrl_hit && (sleep_q || (region == RG_NONE));
    rd_masked  = rd_req && !ctrl_hit && sleep_q;
  end

  psg_ctrl u_ctrl (
    .clk(clk), .rst(rst),
    .ctrl_wr(ctrl_wr), .ctrl_bit(req_wdata[PD_BIT]),
    .en_wr(en_wr), .en_bit(req_wdata[0]),
    .sleep_q(sleep_q), .enable_q(enable_q)
  );

  psg_bank #(.NUM_REGS(NUM_REGS), .DATA_W(DATA_W)) u_bank (
    .clk(clk), .rst(rst), .wr_en(bank_wr), .idx(bank_idx),
    .wdata(req_wdata), .rdata(bank_rdata)
  );

  always_comb begin
    unique case (region)
      RG_CTRL:   rd_value = DATA_W'(ctrl_image(sleep_q, PD_BIT));
      RG_ENABLE: rd_value = DATA_W'(enable_q);
      RG_BANK:   rd_value = bank_rdata;
      default:   rd_value = '0;
    endcase
    if (rd_masked) rd_value = '0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      rsp_rdata <= rd_req ? rd_value : '0;
      rsp_err   <= wr_blocked;
    end
  end

  assign mem_pd_en = sleep_q;
  assign periph_en = enable_q && !sleep_q;
endmodule

// File: rtl/psg_checker.sv
module psg_checker #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int PD_BIT = 31
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [DATA_W-1:0] req_wdata,
  input logic              rsp_valid,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic              rsp_err,
  input logic              mem_pd_en,
  input logic              periph_en,
  input logic              ctrl_hit
);
  a_r2_rsp_follows_req: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> rsp_valid);

  a_r2_no_spurious_rsp: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> !rsp_valid);

  a_r3_pd_takes_bit: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && ctrl_hit) |=>
      (mem_pd_en == $past(req_wdata[PD_BIT])) && !rsp_err);

  a_r3_pd_held: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write && ctrl_hit) |=> $stable(mem_pd_en));

  a_r4_masked_read_zero: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && !ctrl_hit && mem_pd_en) |=>
      (rsp_rdata == '0) && !rsp_err);

  a_r5_fenced_write_err: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_write && !ctrl_hit && mem_pd_en) |=> rsp_err);

  a_r7_enable_low_asleep: assert property (@(posedge clk) disable iff (rst)
    mem_pd_en |-> !periph_en);
endmodule

bind periph_sleep_gate psg_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PD_BIT(PD_BIT)
) u_psg_checker (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
  .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
  .rsp_err(rsp_err), .mem_pd_en(mem_pd_en), .periph_en(periph_en),
  .ctrl_hit(ctrl_hit)
);

// File: tb/periph_sleep_gate_bench.sv
module periph_sleep_gate_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [11:0] A_CTRL = 12'hFF4;
  localparam logic [11:0] A_EN   = 12'h000;
  localparam logic [11:0] A_NONE = 12'h800;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, rsp_err, mem_pd_en, periph_en;
  logic [31:0] rsp_rdata;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [31:0] got_d;
  logic        got_e;

  periph_sleep_gate u_periph_sleep_gate (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .mem_pd_en(mem_pd_en),
    .periph_en(periph_en)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] bank_addr(input int i);
    return 12'(4 + 4*i);
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One request; captures the response one cycle later.
  task automatic access(input logic wr, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk); #1;
    req_valid = 1'b0;
    chk("R2 rsp_valid", 32'(rsp_valid), 32'd1);
    got_d = rsp_rdata; got_e = rsp_err;
  endtask

  task automatic t_reset;
    chk("R1 mem_pd_en", 32'(mem_pd_en), 0);
    chk("R1 periph_en", 32'(periph_en), 0);
    chk("R1 rsp_valid", 32'(rsp_valid), 0);
    access(0, A_EN, 0);          chk("R1 enable reads 0", got_d, 0);
    access(0, bank_addr(3), 0);  chk("R1 bank3 reads 0", got_d, 0);
  endtask

  task automatic t_awake;
    for (int i = 0; i < 4; i++) begin
      access(1, bank_addr(i), 32'hA5000000 + 32'(i * 32'h111));
      chk("R6 bank write no err", 32'(got_e), 0);
    end
    for (int i = 0; i < 4; i++) begin
      access(0, bank_addr(i), 0);
      chk("R6 bank readback", got_d, 32'hA5000000 + 32'(i * 32'h111));
    end
    access(1, A_EN, 32'hFFFF_FFFF);
    chk("R6 enable write no err", 32'(got_e), 0);
    chk("R6 periph_en set", 32'(periph_en), 1);
    access(0, A_EN, 0); chk("R6 enable reads bit0 only", got_d, 1);
  endtask

  task automatic t_ctrl_other_bits;
    access(1, A_CTRL, 32'h7FFF_FFFF);
    chk("R3 ctrl write no err", 32'(got_e), 0);
    chk("R3 low bits ignored", 32'(mem_pd_en), 0);
    access(0, A_CTRL, 0); chk("R3 ctrl reads 0", got_d, 0);
  endtask

  task automatic t_sleep;
    access(1, A_CTRL, 32'h8000_0000);
    chk("R3 sleep write no err", 32'(got_e), 0);
    chk("R3 mem_pd_en set", 32'(mem_pd_en), 1);
    chk("R7 periph_en cleared", 32'(periph_en), 0);
    access(0, A_CTRL, 0); chk("R3 ctrl reads sleep", got_d, 32'h8000_0000);
    chk("R3 ctrl read no err", 32'(got_e), 0);
    access(0, bank_addr(1), 0);
    chk("R4 masked bank read", got_d, 0); chk("R4 no err", 32'(got_e), 0);
    access(0, A_EN, 0); chk("R4 masked enable read", got_d, 0);
    access(1, bank_addr(1), 32'hDEAD_BEEF); chk("R5 fenced bank write err", 32'(got_e), 1);
    access(1, A_EN, 1); chk("R5 fenced enable write err", 32'(got_e), 1);
    chk("R7 periph_en stays low", 32'(periph_en), 0);
    access(1, A_CTRL, 32'h8000_0000); chk("R3 ctrl rewrite asleep no err", 32'(got_e), 0);
  endtask

  task automatic t_wake;
    access(1, A_CTRL, 0);
    chk("R8 mem_pd_en cleared", 32'(mem_pd_en), 0);
    access(0, bank_addr(1), 0); chk("R5 R8 bank1 unchanged", got_d, 32'hA5000111);
    access(0, bank_addr(2), 0); chk("R8 bank2 kept", got_d, 32'hA5000222);
    access(0, A_EN, 0); chk("R7 enable cleared by sleep", got_d, 0);
    access(1, A_EN, 1); chk("R8 enable write ok", 32'(got_e), 0);
    chk("R8 periph_en again", 32'(periph_en), 1);
  endtask

  task automatic t_unmapped;
    access(0, A_NONE, 0);
    chk("R9 unmapped read 0", got_d, 0); chk("R9 unmapped read no err", 32'(got_e), 0);
    access(1, A_NONE, 32'h1234_5678); chk("R9 unmapped write err", 32'(got_e), 1);
    access(0, bank_addr(0), 0); chk("R9 bank0 untouched", got_d, 32'hA5000000);
    access(0, A_EN, 0); chk("R9 enable untouched", got_d, 1);
  endtask

  task automatic t_idle;
    @(negedge clk); @(posedge clk); #1;
    chk("R2 idle no response", 32'(rsp_valid), 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    t_reset();
    t_awake();
    t_idle();
    t_ctrl_other_bits();
    t_sleep();
    t_wake();
    t_unmapped();
    t_idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule